// File: doc/BRIEF.md
# E3 Receive Alarm Monitor

This block sits behind the receive framer of an E3 line interface and watches the aligned bit stream one frame at a time for two defects. The first is the Alarm Indication Signal (AIS), which it judges by counting the zero bits in each frame. The second is the Far-End Receive Failure (FERF), which it judges from the top bit of the MA overhead byte. The framer supplies a serial data bit with a valid strobe, a pulse on the first bit of each frame, and a strobe that presents the MA byte once per frame.

Each frame is judged when the next frame-start pulse arrives. AIS is declared or cleared with a fixed two-frame hysteresis. FERF uses a run length that software sets. Every change of either condition raises a sticky flag that clears when read. The enabled flags are ORed onto a single interrupt line. A small register port gives access to the run length, the interrupt enables, a spare read/write configuration bit and the live alarm states.

Top module: `e3_alarm_mon`

## Requirements
- R1: On each frame-start pulse, the previous frame's zero count is judged; the first pulse after reset only opens a frame. AIS is declared after two consecutive frames that each hold fewer than eight zero bits. A frame with eight or more zeros restarts that run.
- R2: A declared AIS clears after two consecutive frames that each hold eight or more zero bits. Exactly eight zeros qualifies, and a frame with seven zeros restarts the run.
- R3: `ais_pin` is high exactly while AIS is declared. It changes only in the cycle after a frame-start pulse. Bit 3 of the status register at address 0x11 reads the same state.
- R4: FERF is declared after N consecutive frames whose MA byte has bit 7 set, and not earlier. N equals the value of bits [2:0] of the register at address 0x10, plus one, so the range is 1 to 8.
- R5: A declared FERF clears after N consecutive frames whose MA bit 7 is 0. Bit 0 of register 0x11 reads the FERF state.
- R6: In the register at address 0x14, bit 0 flags an AIS change and bit 1 flags a FERF change. Bits 7:2 read as zero. A read of 0x14 clears the flags on the next clock. A change event in the same cycle as that read still leaves its flag set.
- R7: `irq` is high exactly when a flag in 0x14 is set and its enable bit is set. The enables are bit 0 (AIS) and bit 1 (FERF) of the register at address 0x12.
- R8: Read data appears on `rd_data` in the cycle after `rd_en`. Bit 7 of 0x11 is a read/write bit that holds its written value. An unmapped address reads as zero.
- R9: After reset, both alarms are clear, all flags, enables and configuration fields are zero, `ais_pin` is low and `irq` is low.
- R10: A zero bit offered while `bit_vld` is low is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received serial data bit |
| bit_vld | input | 1 | `rx_bit` carries a valid bit this cycle |
| frm_start | input | 1 | First bit of a new frame |
| ma_stb | input | 1 | `ma_byte` holds this frame's MA byte |
| ma_byte | input | 8 | MA overhead byte; bit 7 is the FERF flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Read data, registered |
| ais_pin | output | 1 | Live AIS state |
| irq | output | 1 | OR of enabled change flags |

## Verification
The assertions assume that `frm_start` arrives as a one-cycle pulse, at most once per frame. They also assume that `ma_stb` fires at most once between two frame starts, so each frame carries one MA judgement. The bench keeps to both. It builds frames of a fixed valid-bit length with a single MA strobe at a fixed offset, and it inserts a stalled zero bit in every frame. It keeps register accesses apart from reset. One read of the interrupt register is placed in the same cycle that an AIS change flag is raised.

// File: rtl/e3am_pkg.sv
package e3am_pkg;
  localparam logic [7:0] ADDR_CFG  = 8'h10;
  localparam logic [7:0] ADDR_STAT = 8'h11;
  localparam logic [7:0] ADDR_IEN  = 8'h12;
  localparam logic [7:0] ADDR_ISR  = 8'h14;

  localparam int NUM_IRQ  = 2;
  localparam int IRQ_AIS  = 0;
  localparam int IRQ_FERF = 1;

  typedef struct packed {
    logic cfg_rw;
    logic ais;
    logic ferf;
  } stat_t;
endpackage

// File: rtl/e3am_ais_det.sv
module e3am_ais_det #(
  parameter int ZERO_THR = 8,
  parameter int RUN_LEN  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_bit,
  input  logic bit_vld,
  input  logic frm_start,
  output logic ais_st,
  output logic ais_chg
);
  localparam int CW = $clog2(ZERO_THR + 1);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] zcnt_q;
  logic [RW-1:0] run_q;
  logic          open_q;
  logic          ais_q;
  logic          chg_q;
  logic          zero_in;
  logic          qual;

  always_comb begin
    zero_in = bit_vld & ~rx_bit;
    // a frame counts toward the opposite state
    qual = ais_q ? (zcnt_q >= CW'(ZERO_THR)) : (zcnt_q < CW'(ZERO_THR));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zcnt_q <= '0;
      run_q  <= '0;
      open_q <= 1'b0;
      ais_q  <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (frm_start) begin
        open_q <= 1'b1;
        zcnt_q <= zero_in ? CW'(1) : '0;
        if (open_q) begin
          if (qual) begin
            if (run_q == RW'(RUN_LEN - 1)) begin
              ais_q <= ~ais_q;
              run_q <= '0;
              chg_q <= 1'b1;
            end else begin
              run_q <= run_q + 1'b1;
            end
          end else begin
            run_q <= '0;
          end
        end
      end else if (zero_in && (zcnt_q < CW'(ZERO_THR))) begin
        zcnt_q <= zcnt_q + 1'b1;
      end
    end
  end

  assign ais_st  = ais_q;
  assign ais_chg = chg_q;
endmodule

// File: rtl/e3am_ferf_det.sv
module e3am_ferf_det #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_start,
  input  logic             ma_stb,
  input  logic             ma_flag,
  input  logic [LEN_W-1:0] run_len,
  output logic             ferf_st,
  output logic             ferf_chg
);
  logic [LEN_W-1:0] run_q;
  logic             open_q;
  logic             seen_q;
  logic             flag_q;
  logic             ferf_q;
  logic             chg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      open_q <= 1'b0;
      seen_q <= 1'b0;
      flag_q <= 1'b0;
      ferf_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (frm_start) begin
        open_q <= 1'b1;
        seen_q <= ma_stb;
        flag_q <= ma_stb & ma_flag;
        if (open_q && seen_q) begin
          if (flag_q != ferf_q) begin
            // field value v demands v+1 frames in a row
            if (run_q == run_len) begin
              ferf_q <= flag_q;
              run_q  <= '0;
              chg_q  <= 1'b1;
            end else begin
              run_q <= run_q + 1'b1;
            end
          end else begin
            run_q <= '0;
          end
        end
      end else if (ma_stb) begin
        seen_q <= 1'b1;
        flag_q <= ma_flag;
      end
    end
  end

  assign ferf_st  = ferf_q;
  assign ferf_chg = chg_q;
endmodule

// File: rtl/e3am_regs.sv
module e3am_regs
  import e3am_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic               ais_st,
  input  logic               ferf_st,
  input  logic               ais_chg,
  input  logic               ferf_chg,
  output logic [LEN_W-1:0]   run_len,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_IRQ-1:0] irq_flags,
  output logic               irq
);
  logic [LEN_W-1:0]   len_q;
  logic [NUM_IRQ-1:0] ien_q;
  logic               cfg_rw_q;
  logic [DATA_W-1:0]  rd_q;
  logic [NUM_IRQ-1:0] evt;
  logic               isr_clr;
  logic [7:0]         rd_mux;
  stat_t              stat;

  always_comb begin
    evt            = '0;
    evt[IRQ_AIS]   = ais_chg;
    evt[IRQ_FERF]  = ferf_chg;
    isr_clr        = rd_en && (rd_addr == ADDR_W'(ADDR_ISR));
    stat.cfg_rw    = cfg_rw_q;
    stat.ais       = ais_st;
    stat.ferf      = ferf_st;
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (rst) f_q <= 1'b0;
      else     f_q <= (f_q & ~isr_clr) | evt[g];
    end
    assign irq_flags[g] = f_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q    <= '0;
      ien_q    <= '0;
      cfg_rw_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADDR_CFG))  len_q    <= wr_data[LEN_W-1:0];
      if (wr_addr == ADDR_W'(ADDR_IEN))  ien_q    <= wr_data[NUM_IRQ-1:0];
      if (wr_addr == ADDR_W'(ADDR_STAT)) cfg_rw_q <= wr_data[7];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == ADDR_W'(ADDR_CFG))
      rd_mux = {{(8-LEN_W){1'b0}}, len_q};
    else if (rd_addr == ADDR_W'(ADDR_STAT))
      rd_mux = {stat.cfg_rw, 3'b000, stat.ais, 2'b00, stat.ferf};
    else if (rd_addr == ADDR_W'(ADDR_IEN))
      rd_mux = {{(8-NUM_IRQ){1'b0}}, ien_q};
    else if (rd_addr == ADDR_W'(ADDR_ISR))
      rd_mux = {{(8-NUM_IRQ){1'b0}}, irq_flags};
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= DATA_W'(rd_mux);
  end

  assign run_len = len_q;
  assign rd_data = rd_q;
  assign irq     = |(irq_flags & ien_q);
endmodule

// File: rtl/e3_alarm_mon.sv
module e3_alarm_mon
  import e3am_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int LEN_W    = 3,
  parameter int ZERO_THR = 8,
  parameter int AIS_RUN  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_bit,
  input  logic              bit_vld,
  input  logic              frm_start,
  input  logic              ma_stb,
  input  logic [7:0]        ma_byte,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ais_pin,
  output logic              irq
);
  logic               ais_st;
  logic               ais_chg;
  logic               ferf_st;
  logic               ferf_chg;
  logic [LEN_W-1:0]   run_len;
  logic [NUM_IRQ-1:0] irq_flags;

  e3am_ais_det #(.ZERO_THR(ZERO_THR), .RUN_LEN(AIS_RUN)) u_ais (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .bit_vld(bit_vld),
    .frm_start(frm_start), .ais_st(ais_st), .ais_chg(ais_chg)
  );

  e3am_ferf_det #(.LEN_W(LEN_W)) u_ferf (
    .clk(clk), .rst(rst), .frm_start(frm_start), .ma_stb(ma_stb),
    .ma_flag(ma_byte[7]), .run_len(run_len),
    .ferf_st(ferf_st), .ferf_chg(ferf_chg)
  );

  e3am_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .ais_st(ais_st), .ferf_st(ferf_st),
    .ais_chg(ais_chg), .ferf_chg(ferf_chg), .run_len(run_len),
    .rd_data(rd_data), .irq_flags(irq_flags), .irq(irq)
  );

  assign ais_pin = ais_st;
endmodule

// File: rtl/e3am_chk.sv
module e3am_chk
  import e3am_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              frm_start,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              ais_pin,
  input logic              ferf_st,
  input logic              irq,
  input logic [1:0]        irq_flags
);
  logic isr_rd;
  logic stat_rd;
  assign isr_rd  = rd_en && (rd_addr == ADDR_W'(ADDR_ISR));
  assign stat_rd = rd_en && (rd_addr == ADDR_W'(ADDR_STAT));

  a_r3_ais_frame_aligned: assert property (@(posedge clk) disable iff (rst)
    !frm_start |=> $stable(ais_pin));

  a_r4_ferf_frame_aligned: assert property (@(posedge clk) disable iff (rst)
    !frm_start |=> $stable(ferf_st));

  a_r3_status_mirror: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (rd_data[3] == $past(ais_pin)));

  a_r6_ais_change_flagged: assert property (@(posedge clk) disable iff (rst)
    ($rose(ais_pin) || $fell(ais_pin)) |=> irq_flags[0]);

  a_r6_ferf_change_flagged: assert property (@(posedge clk) disable iff (rst)
    ($rose(ferf_st) || $fell(ferf_st)) |=> irq_flags[1]);

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_flags[0] && !isr_rd) |=> irq_flags[0]);

  a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
    isr_rd |=> (rd_data[7:2] == 6'd0));

  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> (irq_flags != 2'b00));
endmodule

bind e3_alarm_mon e3am_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .frm_start(frm_start), .rd_en(rd_en),
  .rd_addr(rd_addr), .rd_data(rd_data), .ais_pin(ais_pin),
  .ferf_st(ferf_st), .irq(irq), .irq_flags(irq_flags)
);

// File: tb/sim_e3_alarm_mon.sv
`timescale 1ns/1ps
module sim_e3_alarm_mon;
  localparam int FRAME = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit = 1'b1, bit_vld = 1'b0, frm_start = 1'b0, ma_stb = 1'b0;
  logic [7:0] ma_byte = 8'h00;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_addr = 8'h00, wr_data = 8'h00, rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic       ais_pin, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  e3_alarm_mon u0 (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .bit_vld(bit_vld),
    .frm_start(frm_start), .ma_stb(ma_stb), .ma_byte(ma_byte),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ais_pin(ais_pin), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h @%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_zc, m_open, m_ais, m_arun, m_ferf, m_frun, m_mseen, m_mbit;
  int m_flags, m_pend, m_len, m_c7, m_ien, m_rd, m_irq;
  bit m_rdchk, m_live;

  always @(posedge clk) begin
    int rdv, nflags, zeros, q;
    m_rdchk = 0;
    if (rst) begin
      m_zc = 0; m_open = 0; m_ais = 0; m_arun = 0; m_ferf = 0; m_frun = 0;
      m_mseen = 0; m_mbit = 0; m_flags = 0; m_pend = 0; m_len = 0;
      m_c7 = 0; m_ien = 0; m_rd = 0; m_irq = 0; m_live = 0;
    end else begin
      m_live = 1;
      case (rd_addr)
        8'h10:   rdv = m_len;
        8'h11:   rdv = (m_c7 << 7) | (m_ais << 3) | m_ferf;
        8'h12:   rdv = m_ien;
        8'h14:   rdv = m_flags;
        default: rdv = 0;
      endcase
      if (rd_en) begin m_rd = rdv; m_rdchk = 1; end
      nflags = (rd_en && rd_addr == 8'h14) ? 0 : m_flags;
      nflags = nflags | m_pend;
      m_pend = 0;
      if (frm_start && m_open != 0) begin
        zeros = m_zc;
        q = (m_ais != 0) ? (zeros >= 8) : (zeros < 8);
        if (q != 0) begin
          m_arun++;
          if (m_arun == 2) begin m_ais = 1 - m_ais; m_arun = 0; m_pend |= 1; end
        end else m_arun = 0;
        if (m_mseen != 0) begin
          if (m_mbit != m_ferf) begin
            m_frun++;
            if (m_frun == m_len + 1) begin m_ferf = m_mbit; m_frun = 0; m_pend |= 2; end
          end else m_frun = 0;
        end
      end
      if (frm_start) begin
        m_open = 1;
        m_zc = (bit_vld && !rx_bit) ? 1 : 0;
        m_mseen = ma_stb ? 1 : 0;
        m_mbit = (ma_stb && ma_byte[7]) ? 1 : 0;
      end else begin
        if (bit_vld && !rx_bit && m_zc < 8) m_zc++;
        if (ma_stb) begin m_mseen = 1; m_mbit = ma_byte[7] ? 1 : 0; end
      end
      if (wr_en) begin
        if (wr_addr == 8'h10) m_len = wr_data[2:0];
        if (wr_addr == 8'h12) m_ien = wr_data[1:0];
        if (wr_addr == 8'h11) m_c7 = wr_data[7];
      end
      m_flags = nflags;
      m_irq = ((m_flags & m_ien) != 0) ? 1 : 0;
    end
    #1;
    if (m_live) begin
      chk("R3 ais_pin vs model", ais_pin, m_ais);
      chk("R7 irq vs model", irq, m_irq);
      if (m_rdchk) chk("R8 rd_data vs model", rd_data, m_rd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  // frame of FRAME valid bits, nz leading zeros, one stalled zero bit, one MA strobe
  task automatic frame(input int nz, input bit ma7, input bit rd_mid);
    for (int i = 0; i < FRAME; i++) begin
      if (i == 5) begin
        bit_vld = 1'b0; rx_bit = 1'b0; frm_start = 1'b0; ma_stb = 1'b0;
        @(negedge clk);
      end
      bit_vld   = 1'b1;
      rx_bit    = (i < nz) ? 1'b0 : 1'b1;
      frm_start = (i == 0);
      ma_stb    = (i == 8);
      ma_byte   = (i == 8) ? {ma7, 7'h2A} : 8'h00;
      rd_en     = rd_mid && (i == 1);
      rd_addr   = 8'h14;
      @(negedge clk);
    end
    bit_vld = 1'b0; frm_start = 1'b0; ma_stb = 1'b0; rd_en = 1'b0; rx_bit = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R9 reset state
    chk("R9 ais_pin after reset", ais_pin, 0);
    chk("R9 irq after reset", irq, 0);
    rd(8'h11, v); chk("R9 status after reset", v, 8'h00);
    rd(8'h14, v); chk("R9 flags after reset", v, 8'h00);
    rd(8'h10, v); chk("R9 run length after reset", v, 8'h00);

    wr(8'h12, 8'h03);
    wr(8'h10, 8'h02);          // FERF needs 3 frames

    frame(20, 0, 0);           // F0 opens
    frame(3, 0, 0);            // F0 judged: no
    frame(20, 0, 0);           // F1 judged: run 1
    frame(3, 0, 0);            // F2 judged: run restarts
    chk("R1 single bad frame no AIS", ais_pin, 0);
    frame(3, 0, 0);
    chk("R1 run not complete", ais_pin, 0);
    frame(8, 0, 0);            // F4 judged: declare
    chk("R1 AIS declared", ais_pin, 1);
    rd(8'h14, v); chk("R6 AIS change flag", v, 8'h01);
    rd(8'h14, v); chk("R6 cleared by read", v, 8'h00);
    rd(8'h11, v); chk("R3 status AIS bit", v, 8'h08);

    frame(7, 0, 0);            // F5 (8 zeros) judged: clear run 1
    frame(8, 0, 0);            // F6 (7 zeros + stalled zero) judged: restart
    chk("R10 stalled zero not counted", ais_pin, 1);
    frame(8, 0, 0);            // F7 judged: run 1
    chk("R2 AIS held", ais_pin, 1);
    frame(20, 0, 1);           // F8 judged: clear, read collides with flag set
    chk("R2 AIS cleared at eight zeros", ais_pin, 0);
    rd(8'h14, v); chk("R6 event beats same-cycle clear", v, 8'h01);

    frame(20, 1, 0);
    frame(20, 1, 0);
    frame(20, 1, 0);
    rd(8'h11, v); chk("R4 FERF not early", v, 8'h00);
    frame(20, 0, 0);
    rd(8'h11, v); chk("R4 FERF declared after 3", v, 8'h01);
    rd(8'h14, v); chk("R6 FERF change flag", v, 8'h02);

    wr(8'h10, 8'h00);          // one frame
    frame(20, 0, 0);
    rd(8'h11, v); chk("R5 FERF cleared after 1", v, 8'h00);
    rd(8'h14, v); chk("R6 FERF clear flag", v, 8'h02);

    wr(8'h10, 8'h07);          // eight frames
    for (int k = 0; k < 8; k++) frame(20, 1, 0);
    rd(8'h11, v); chk("R4 FERF not after 7 of 8", v, 8'h00);
    frame(20, 0, 0);
    rd(8'h11, v); chk("R4 FERF declared after 8", v, 8'h01);

    wr(8'h11, 8'h80);
    rd(8'h11, v); chk("R8 rw config bit", v, 8'h81);
    rd(8'h10, v); chk("R8 run length readback", v, 8'h07);
    rd(8'h3F, v); chk("R8 unmapped reads zero", v, 8'h00);

    wr(8'h12, 8'h00);
    chk("R7 irq masked", irq, 0);
    wr(8'h12, 8'h01);
    chk("R7 irq other source", irq, 0);
    wr(8'h12, 8'h02);
    chk("R7 irq enabled", irq, 1);
    rd(8'h14, v); chk("R6 flag before clear", v, 8'h02);
    chk("R7 irq after clear", irq, 0);

    frame(3, 1, 0);
    frame(3, 1, 0);
    frame(20, 1, 0);
    chk("R1 AIS declared again", ais_pin, 1);

    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
    chk("R9 ais_pin cleared by reset", ais_pin, 0);
    chk("R9 irq cleared by reset", irq, 0);
    rd(8'h11, v); chk("R9 status cleared by reset", v, 8'h00);
    rd(8'h14, v); chk("R9 flags cleared by reset", v, 8'h00);
    idle(2);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule